// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider Bank

This block derives three clock outputs from a single reference clock. Each output is driven by its own phase counter, which holds the output high for a programmed number of reference cycles and then low for a second programmed number of cycles. The two lengths are set separately, so both the division ratio and the duty cycle of each output are free. All three outputs are registered, so they change only on a reference edge and never glitch.

A shared run enable and a shared reset/resync input gate the whole bank. While either is active, the outputs are held at 0, the counters are cleared and the lock flag is low. When both are released, every output starts its high phase on the same reference edge, so the rising edges of the outputs line up. The lock flag rises a fixed number of cycles after that restart. Phase lengths are sampled only while the bank is gated. Values that change while the bank runs wait for the next restart.

Top module: `duty_div_bank`

## Requirements
- R1: Each output channel repeats a pattern of `hi` reference cycles at 1 followed by `lo` reference cycles at 0. Counted from the first running edge k = 0, the output after edge k is 1 exactly when k mod (hi + lo) < hi.
- R2: A programmed phase length of 0 acts as a length of 1, so an output never stalls at one level.
- R3: When `run_en` is sampled low on an edge, all of `clk_out` is 0 and `locked` is 0 after that edge, and they stay so while `run_en` stays low.
- R4: When `rst` is sampled high on an edge, all of `clk_out` is 0 and `locked` is 0 after that edge, and the phase counters restart from zero.
- R5: On the first edge at which `rst` is low and `run_en` is high after a gated period, every output goes to 1, so all channels start their high phase on the same edge.
- R6: `locked` becomes 1 after the 4th running edge following a restart (LOCK_CYCLES = 4), which is after edge k = 3. It stays 1 until the bank is gated again.
- R7: Phase lengths are captured on every gated edge. A change to `high_len` or `low_len` while the bank runs has no effect on any output until the next restart.
- R8: Each phase length is 8 bits wide. Channel i takes its high length from `high_len[8*i+7:8*i]` and its low length from `low_len[8*i+7:8*i]`, and drives `clk_out[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset and resync of all channels |
| run_en | input | 1 | Bank enable. Low holds all outputs at 0 |
| high_len | input | 24 | Per-channel high-phase length, 8 bits per channel |
| low_len | input | 24 | Per-channel low-phase length, 8 bits per channel |
| clk_out | output | 3 | Derived clock outputs, one bit per channel |
| locked | output | 1 | Restart complete and outputs running |

## Verification
The assertions take for granted that `rst` is high from the first clock edge, because the release check compares each edge with the gate value of the edge before. They also assume the phase lengths are stable on the last gated edge before a release. The stimulus changes `rst`, `run_en` and the length inputs only on falling clock edges. Each restart keeps the bank gated for at least two edges with the new lengths already applied. Lengths written mid-run are deliberately changed only while the bank runs, so the no-effect rule is the only one they touch.

// File: rtl/ddiv_pkg.sv
package ddiv_pkg;

    // Width of one phase-length field
    localparam int LEN_W = 8;

    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

    // Captured configuration of one channel
    typedef struct packed {
        len_t hi;
        len_t lo;
    } phase_cfg_t;

    // Running state of one channel
    typedef struct packed {
        logic   live;
        level_e lvl;
        len_t   left;
    } phase_st_t;

    // Number of extra cycles to wait after a phase starts.
    // A length of zero is treated as one, so it reloads zero.
    function automatic len_t reload_of(input len_t len);
        return (len == '0) ? '0 : len_t'(len - len_t'(1));
    endfunction

endpackage

// File: rtl/ddiv_lock_mon.sv
module ddiv_lock_mon #(
    parameter int LOCK_CYCLES = 4
) (
    input  logic clk,
    input  logic hold,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (hold) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(LOCK_CYCLES)) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    assign locked = (run_cnt == CW'(LOCK_CYCLES));

endmodule

// File: rtl/ddiv_channel.sv
module ddiv_channel
    import ddiv_pkg::*;
(
    input  logic clk,
    input  logic hold,
    input  len_t hi_len,
    input  len_t lo_len,
    output logic tick_out
);
    phase_cfg_t cfg;
    phase_st_t  st;

    // Lengths are sampled only while the bank is gated
    always_ff @(posedge clk) begin
        if (hold) begin
            cfg.hi <= hi_len;
            cfg.lo <= lo_len;
        end
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            st.live <= 1'b0;
            st.lvl  <= LVL_LOW;
            st.left <= '0;
        end else if (!st.live) begin
            st.live <= 1'b1;
            st.lvl  <= LVL_HIGH;
            st.left <= reload_of(cfg.hi);
        end else if (st.left == '0) begin
            if (st.lvl == LVL_HIGH) begin
                st.lvl  <= LVL_LOW;
                st.left <= reload_of(cfg.lo);
            end else begin
                st.lvl  <= LVL_HIGH;
                st.left <= reload_of(cfg.hi);
            end
        end else begin
            st.left <= st.left - len_t'(1);
        end
    end

    assign tick_out = (st.lvl == LVL_HIGH);

endmodule

// File: rtl/duty_div_bank.sv
module duty_div_bank
    import ddiv_pkg::*;
#(
    parameter int NUM_OUT     = 3,
    parameter int LOCK_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_en,
    input  logic [NUM_OUT*LEN_W-1:0] high_len,
    input  logic [NUM_OUT*LEN_W-1:0] low_len,
    output logic [NUM_OUT-1:0]       clk_out,
    output logic                     locked
);
    logic hold;

    assign hold = rst | ~run_en;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
        ddiv_channel u_ch (
            .clk      (clk),
            .hold     (hold),
            .hi_len   (high_len[g*LEN_W +: LEN_W]),
            .lo_len   (low_len[g*LEN_W +: LEN_W]),
            .tick_out (clk_out[g])
        );
    end

    ddiv_lock_mon #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk    (clk),
        .hold   (hold),
        .locked (locked)
    );

endmodule

// File: rtl/duty_div_bank_chk.sv
module duty_div_bank_chk #(
    parameter int NUM_OUT     = 3,
    parameter int LOCK_CYCLES = 4,
    parameter int LEN_W       = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               run_en,
    input logic [NUM_OUT-1:0] clk_out,
    input logic               locked
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam int SW = LEN_W + 2;

    logic          gate;
    logic          gate_d;
    logic [CW-1:0] seen;

    assign gate = rst | ~run_en;

    always_ff @(posedge clk) begin
        gate_d <= gate;
        if (gate) begin
            seen <= '0;
        end else if (seen != CW'(LOCK_CYCLES)) begin
            seen <= seen + CW'(1);
        end
    end

    // R3
    en_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (clk_out == '0) && !locked);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_d && !gate) |=> (clk_out == '1));

    // R6
    lock_early_chk: assert property (@(posedge clk) disable iff (rst)
        locked |-> (seen == CW'(LOCK_CYCLES)));

    // R6
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(gate));

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_stay
        logic [SW-1:0] stay;
        always_ff @(posedge clk) begin
            if (gate || (clk_out[g] != $past(clk_out[g]))) begin
                stay <= '0;
            end else if (stay != '1) begin
                stay <= stay + SW'(1);
            end
        end
        // R2
        no_stall_chk: assert property (@(posedge clk) disable iff (rst)
            stay <= SW'(2 ** LEN_W));
    end

endmodule

bind duty_div_bank duty_div_bank_chk #(
    .NUM_OUT     (NUM_OUT),
    .LOCK_CYCLES (LOCK_CYCLES),
    .LEN_W       (ddiv_pkg::LEN_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .clk_out (clk_out),
    .locked  (locked)
);

// File: tb/duty_div_bank_tb.sv
module duty_div_bank_tb;
    localparam int N    = 3;
    localparam int W    = 8;
    localparam int LOCK = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic [N*W-1:0] high_len = '0;
    logic [N*W-1:0] low_len = '0;
    logic [N-1:0] clk_out;
    logic         locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    duty_div_bank u_dut (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .high_len (high_len),
        .low_len  (low_len),
        .clk_out  (clk_out),
        .locked   (locked)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_level(input int h, input int l, input int k);
        int he = (h == 0) ? 1 : h;
        int le = (l == 0) ? 1 : l;
        return (k % (he + le)) < he;
    endfunction

    task automatic segment(input int hv[N], input int lv[N], input bit via_rst,
                           input int ncyc, input bit poke);
        string greq;
        @(negedge clk);
        if (via_rst) rst = 1'b1; else run_en = 1'b0;
        for (int i = 0; i < N; i++) begin
            high_len[i*W +: W] = W'(hv[i]);
            low_len[i*W +: W]  = W'(lv[i]);
        end
        greq = via_rst ? "R4" : "R3";
        for (int g = 0; g < 2; g++) begin
            @(negedge clk);
            chk(clk_out == '0, greq, int'(clk_out), 0);
            chk(locked == 1'b0, greq, int'(locked), 0);
        end
        rst = 1'b0;
        run_en = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                string req;
                bit e = exp_level(hv[i], lv[i], k);
                if (poke && k > 5) req = "R7";
                else if (hv[i] == 0 || lv[i] == 0) req = "R2";
                else req = "R1 R8";
                chk(clk_out[i] == e, req, int'(clk_out[i]), int'(e));
            end
            if (k == 0) chk(clk_out == '1, "R5", int'(clk_out), 7);
            chk(locked == (k >= LOCK - 1), "R6", int'(locked), int'(k >= LOCK - 1));
            if (poke && k == 5) begin
                high_len = ~high_len;
                low_len  = low_len ^ 24'h5a5a5a;
            end
        end
    endtask

    initial begin
        int hv[N];
        int lv[N];
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        chk(clk_out == '0, "R4", int'(clk_out), 0);
        chk(locked == 1'b0, "R4", int'(locked), 0);

        hv = '{1, 1, 1};   lv = '{1, 1, 1};   segment(hv, lv, 1'b1, 12, 1'b0);
        hv = '{2, 3, 4};   lv = '{5, 1, 2};   segment(hv, lv, 1'b0, 40, 1'b0);
        hv = '{0, 0, 5};   lv = '{0, 3, 0};   segment(hv, lv, 1'b1, 20, 1'b0);
        hv = '{3, 6, 2};   lv = '{2, 1, 7};   segment(hv, lv, 1'b0, 60, 1'b1);
        hv = '{255, 1, 7}; lv = '{1, 255, 9}; segment(hv, lv, 1'b1, 300, 1'b0);
        hv = '{255, 128, 0}; lv = '{255, 0, 64}; segment(hv, lv, 1'b0, 520, 1'b0);

        for (int s = 0; s < 24; s++) begin
            for (int i = 0; i < N; i++) begin
                hv[i] = int'($urandom % 10);
                lv[i] = int'($urandom % 10);
            end
            segment(hv, lv, bit'($urandom % 2), 45, bit'($urandom % 3 == 0));
        end

        // R3: long enable-low hold keeps everything quiet
        @(negedge clk);
        run_en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(clk_out == '0, "R3", int'(clk_out), 0);
            chk(locked == 1'b0, "R3", int'(locked), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule